// File: doc/BRIEF.md
# System Tick Down-Counter

This block is a periodic 24-bit down-counter that a microcontroller core uses as its system heartbeat. Software reaches it through a simple register bus with separate read and write strobes. The bus exposes three words: a control and status word, a reload value and the current count.

Once enabled, the counter steps down by one on every decrement strobe. The strobe comes either from the core clock or from an external one-cycle tick-enable input.

When a strobe finds the counter at zero, the counter takes the reload value; it never rolls over to all ones. It therefore rests at zero for one full strobe period before each reload. Each step from one to zero latches a sticky flag. If software has enabled it, that step also raises a single-cycle interrupt request.

Top module: `systick_timer`

## Requirements
- R1: While enabled, each decrement strobe lowers a nonzero count by exactly one.
- R2: A strobe that finds the count at zero loads the 24-bit reload value. The count never wraps to all ones, and it spends one whole strobe period at zero before the load.
- R3: Setting the enable bit (bit 0 of the control word at address 0) does not load the counter. The count changes only on strobes, and with enable clear, external ticks leave it unchanged.
- R4: Any bus write to the current-count word (address 2) sets the count to zero, whatever the data. That write also clears the sticky flag.
- R5: The sticky flag reads as bit 16 of the control word. It sets on a strobe that moves the count from 1 to 0. It clears after a bus read of the control word, and a set in the same cycle wins.
- R6: When interrupt enable (control bit 1) is set, `irq` is high for exactly one cycle: the cycle after the edge at which the count goes from 1 to 0.
- R7: With a reload value of zero, the counter stays at zero and produces no further flags or interrupts.
- R8: Control bit 2 selects the strobe. A 1 makes every core clock cycle a strobe; a 0 uses `ext_tick`.
- R9: The reload word is address 1. Bits 31:24 of the reload and current-count words read as zero and ignore writes.
- R10: After reset, all three words read zero and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_tick | input | 1 | External one-cycle tick enable |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (used to clear the flag) |
| bus_addr | input | 2 | Word address: 0 control, 1 reload, 2 current count |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Single-cycle interrupt request |

## Verification
The counting path is driven with a table of reload values and tick counts. The table covers:
- a mid-range reload stopped before, at and after zero, which separates decrement, the rest at zero and reload;
- the all-ones 24-bit reload, which exposes any wrap to all ones;
- a reload of one, which exposes an off-by-one in the zero rest;
- a reload of zero, which must stay silent.

Directed cases then cover:
- the core-clock strobe against the external one;
- ticks while disabled;
- enabling with no tick;
- writes of nonzero data to the count;
- upper-bit masking;
- the flag read-clear sequence and the one-cycle interrupt pulse.

// File: rtl/systick_timer.sv
module systick_timer #(
  parameter int CW = 24,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_tick,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq
);
  localparam int PAD = DW - CW;
  localparam int FLAG_BIT = 16;

  logic          en_q, tint_q, src_q, flag_q, irq_q;
  logic [CW-1:0] reload_q, cur_q;

  wire strobe   = en_q & (src_q | ext_tick);
  wire wr_ctl   = bus_wr & (bus_addr == 2'd0);
  wire wr_rld   = bus_wr & (bus_addr == 2'd1);
  wire wr_cur   = bus_wr & (bus_addr == 2'd2);
  wire rd_ctl   = bus_rd & (bus_addr == 2'd0);
  wire hit_zero = strobe & (cur_q == CW'(1)) & ~wr_cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      tint_q   <= 1'b0;
      src_q    <= 1'b0;
      flag_q   <= 1'b0;
      irq_q    <= 1'b0;
      reload_q <= '0;
      cur_q    <= '0;
    end else begin
      if (wr_ctl) begin
        en_q   <= bus_wdata[0];
        tint_q <= bus_wdata[1];
        src_q  <= bus_wdata[2];
      end
      if (wr_rld) reload_q <= bus_wdata[CW-1:0];
      if (wr_cur)      cur_q <= '0;
      else if (strobe) cur_q <= (cur_q == '0) ? reload_q : cur_q - CW'(1);
      if (hit_zero)              flag_q <= 1'b1;
      else if (wr_cur || rd_ctl) flag_q <= 1'b0;
      irq_q <= hit_zero & tint_q;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      2'd0: begin
        bus_rdata[0]        = en_q;
        bus_rdata[1]        = tint_q;
        bus_rdata[2]        = src_q;
        bus_rdata[FLAG_BIT] = flag_q;
      end
      2'd1:    bus_rdata = {{PAD{1'b0}}, reload_q};
      2'd2:    bus_rdata = {{PAD{1'b0}}, cur_q};
      default: bus_rdata = '0;
    endcase
  end

  assign irq = irq_q;

  // R1
  dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && cur_q != '0 && !wr_cur) |=> (cur_q == $past(cur_q) - CW'(1)));

  // R2
  wrap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && cur_q == '0 && !wr_cur) |=> (cur_q == $past(reload_q)));

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe && !wr_cur) |=> $stable(cur_q));

  // R4
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cur |=> (cur_q == '0 && !flag_q));

  // R6
  irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flag_q && cur_q == '0 && tint_q));

  // R6
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R7
  zero_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q == '0 && reload_q == '0 && !wr_rld) |=> (cur_q == '0 && !irq));
endmodule

// File: tb/systick_timer_bench.sv
module systick_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  localparam logic [23:0] V_RLD [NV] = '{24'd5, 24'd5, 24'd5, 24'd5, 24'd0, 24'hFFFFFF, 24'd1, 24'd1};
  localparam int          V_TCK [NV] = '{1, 3, 6, 7, 4, 2, 2, 3};
  localparam logic [23:0] V_EXP [NV] = '{24'd5, 24'd3, 24'd0, 24'd5, 24'd0, 24'hFFFFFE, 24'd0, 24'd1};

  logic clk = 1'b0, rst_n = 1'b0, ext_tick = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq;
  int checks = 0, fails = 0, cycles = 0;
  logic [31:0] rv;

  systick_timer u_systick_timer (.clk(clk), .rst_n(rst_n), .ext_tick(ext_tick),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic tick;
    @(negedge clk);
    ext_tick = 1'b1;
    @(negedge clk);
    ext_tick = 1'b0;
  endtask

  task automatic finish_up;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        checks++; fails++;
        $display("FAIL watchdog: actual %0d expected <100000 cycles", cycles);
        finish_up();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    rd(2'd0, rv); check("R10 ctrl", rv, 32'h0);
    rd(2'd1, rv); check("R10 reload", rv, 32'h0);
    rd(2'd2, rv); check("R10 current", rv, 32'h0);
    check("R10 irq", {31'b0, irq}, 32'h0);

    // R9 upper bits
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, rv); check("R9 reload mask", rv, 32'h00FF_FFFF);

    // R1 R2 R7 vector table, external strobe
    for (int i = 0; i < NV; i++) begin
      wr(2'd0, 32'h0);
      wr(2'd1, {8'h0, V_RLD[i]});
      wr(2'd2, 32'h0);
      wr(2'd0, 32'h1);
      for (int k = 0; k < V_TCK[i]; k++) tick();
      rd(2'd2, rv);
      check($sformatf("R1/R2 vector %0d", i), rv, {8'h0, V_EXP[i]});
    end

    // R3 enable without tick does not load
    wr(2'd0, 32'h0); wr(2'd1, 32'd9); wr(2'd2, 32'h0); wr(2'd0, 32'h1);
    repeat (4) @(negedge clk);
    rd(2'd2, rv); check("R3 enable no load", rv, 32'h0);
    // R3 disabled ignores ticks
    tick(); tick();
    wr(2'd0, 32'h0);
    tick(); tick(); tick();
    rd(2'd2, rv); check("R3 disabled hold", rv, 32'd8);

    // R4 write of nonzero data clears
    wr(2'd2, 32'h0012_3456);
    rd(2'd2, rv); check("R4 write clears", rv, 32'h0);

    // R5 R6 flag and interrupt pulse
    wr(2'd1, 32'd2); wr(2'd0, 32'h3); rd(2'd0, rv);
    tick(); check("R6 no irq on load", {31'b0, irq}, 32'h0);
    tick(); check("R6 no irq at 1", {31'b0, irq}, 32'h0);
    tick(); check("R6 irq pulse", {31'b0, irq}, 32'h1);
    @(negedge clk); check("R6 irq one cycle", {31'b0, irq}, 32'h0);
    rd(2'd0, rv); check("R5 flag set", rv, 32'h0001_0003);
    rd(2'd0, rv); check("R5 flag read-cleared", rv, 32'h0000_0003);
    // R4 write clears flag
    tick(); tick(); tick();
    wr(2'd2, 32'h5);
    rd(2'd0, rv); check("R4 write clears flag", rv, 32'h0000_0003);

    // R7 zero reload stays quiet
    wr(2'd0, 32'h0); wr(2'd1, 32'h0); wr(2'd2, 32'h0); wr(2'd0, 32'h3);
    for (int k = 0; k < 5; k++) begin
      tick();
      check("R7 no irq", {31'b0, irq}, 32'h0);
    end
    rd(2'd0, rv); check("R7 no flag", rv, 32'h0000_0003);

    // R8 core clock strobe
    wr(2'd0, 32'h0); wr(2'd1, 32'd3); wr(2'd2, 32'h0);
    wr(2'd0, 32'h5);
    repeat (2) @(posedge clk);
    @(negedge clk);
    #1 bus_addr = 2'd2;
    #1 check("R8 core clock count", bus_rdata, 32'd2);
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1 check("R8 core clock reload", bus_rdata, 32'd3);

    finish_up();
  end
endmodule